// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects interrupt requests from two groups of sources and presents one request line to a processor. A primary group of 40 sources and a secondary group of 32 sources each hold a pending flag and an enable flag for every source. The secondary group does not drive the processor directly. The OR of its enabled, pending sources becomes primary source 0, so the whole secondary group is served through one primary slot.

Software reaches the block through a 32-bit register bus with word addresses. Enable flags and pending flags never take a plain write. Writing 1 to a bit of a set register or a clear register changes that bit, and writing 0 changes nothing. An index register gives the number of the most urgent enabled, pending primary source. Before the number is returned it passes through a table of per-channel remap registers. A handler reads that number and, if it is 0, goes on to the secondary status word.

Raw inputs are taken to be synchronous to `clk`. A request is a rising edge on a raw input, and the pending flag then stays set until software clears it.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, every pending flag and every enable flag is 0. The index register (word 16, byte 0x40) reads 40, `cpu_irq` is low, and channel-map register c reads c.
- R2: A rising edge on a raw primary or secondary input sets that source's pending flag at the clock edge where the input is first seen high. A high input that stays high does not set the flag again after it has been cleared.
- R3: Writing 1 to bit b of a pending-clear word clears the matching pending flag. Primary sources 0–31 use word 4 (0x10) and sources 32–39 use bits 7:0 of word 5 (0x14). A 0 bit has no effect. If a clear and a new rising edge reach the same source in the same cycle, the flag stays set.
- R4: Writing 1 to a bit of an enable-set word enables that source, and writing 1 to a bit of an enable-clear word disables it. The primary enable-set words are 8 and 9 (0x20/0x24) and the primary enable-clear words are 12 and 13 (0x30/0x34). A 0 bit has no effect. Reading an enable-set word returns the current enable mask.
- R5: Reading a status word returns the pending flags whether or not the sources are enabled. Word 0 holds primary sources 0–31. Word 1 holds sources 32–39 in bits 7:0 and reads 0 in its upper bits.
- R6: The index register returns, in bits 5:0, the mapped number of the lowest-numbered primary source that is both enabled and pending. It returns 40 when there is no such source.
- R7: `cpu_irq` is high exactly when at least one primary source is both enabled and pending.
- R8: Primary source 0 is pending exactly while some enabled secondary source is pending. It is not latched, so a pending-clear of primary bit 0 has no effect. Clearing the secondary source removes it.
- R9: The secondary registers sit at byte 0x80 + 8×reg: status at word 32, pending-clear at word 34, enable-set at word 36 and enable-clear at word 38. Bit b is secondary source b.
- R10: Channel-map register c sits at byte 0x200 + 4c (word 128 + c). It holds 6 bits and can be read back. When channel c wins, the index register reports the value held in that register.
- R11: Reads of an address with no register return 0. This includes the pending-clear and enable-clear words and the words just past the channel map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pri_in | input | 39 | Raw requests for primary sources 1–39 (bit n-1 is source n) |
| irq_sec_in | input | 32 | Raw requests for secondary sources 0–31 |
| cpu_irq | output | 1 | Request line to the processor |

## Verification
The hardest case to reach is a pending-clear write landing in the same cycle as a fresh rising edge on the same source. The bench lowers the raw input first. On one falling clock edge it then raises the input and drives the clear write together, so that the next rising edge sees both. The cascade path is reached only after its two separate enables are set, the secondary one and then primary bit 0. Each step is checked on its own, so that a half-enabled cascade can be seen to stay silent.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned IDX_W  = 6;
   localparam int unsigned WORD_W = 32;

   // word addresses (byte offset / 4)
   localparam int unsigned A_PSTAT  = 0;
   localparam int unsigned A_PCLR   = 4;
   localparam int unsigned A_PESET  = 8;
   localparam int unsigned A_PECLR  = 12;
   localparam int unsigned A_INDEX  = 16;
   localparam int unsigned A_SSTAT  = 32;
   localparam int unsigned A_SCLR   = 34;
   localparam int unsigned A_SESET  = 36;
   localparam int unsigned A_SECLR  = 38;
   localparam int unsigned A_CMAP   = 128;

   typedef logic [IDX_W-1:0]  idx_t;
   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
   parameter int unsigned N        = 32,
   parameter bit          CASCADE0 = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   input  logic [N-1:0] pclr,
   input  logic [N-1:0] eset,
   input  logic [N-1:0] eclr,
   output logic [N-1:0] pend,
   output logic [N-1:0] en
);
   // bit 0 follows its input as a level when it carries a cascade
   localparam logic [N-1:0] LEVEL_MASK = CASCADE0 ? N'(1) : '0;
   localparam logic [N-1:0] LATCH_MASK = ~LEVEL_MASK;

   logic [N-1:0] raw_q, lat, rise;

   assign rise = raw & ~raw_q & LATCH_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         lat   <= '0;
         en    <= '0;
      end else begin
         raw_q <= raw;
         lat   <= ((lat & ~pclr) | rise) & LATCH_MASK;
         en    <= (en | eset) & ~eclr;
      end
   end

   assign pend = lat | (raw & LEVEL_MASK);

   p_edge_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((lat & $past(rise)) == $past(rise)));

   p_hold_until_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((lat & ~pclr) != '0) |=> ((lat & $past(lat & ~pclr)) == $past(lat & ~pclr)));

   p_enable_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (eclr != '0) |=> ((en & $past(eclr)) == '0));

   p_enable_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((eset & ~eclr) != '0) |=> ((en & $past(eset & ~eclr)) == $past(eset & ~eclr)));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int unsigned N  = 40,
   parameter int unsigned IW = 6
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irqc_chanmap.sv
module irqc_chanmap #(
   parameter int unsigned N  = 40,
   parameter int unsigned IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [IW-1:0] wsel,
   input  logic [IW-1:0] wdata,
   input  logic [IW-1:0] rsel,
   output logic [IW-1:0] rdata,
   input  logic [IW-1:0] lsel,
   output logic [IW-1:0] ldata
);
   logic [IW-1:0] map [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) map[i] <= IW'(i);
      end else if (wr && (int'(wsel) < N)) begin
         map[wsel] <= wdata;
      end
   end

   assign rdata = (int'(rsel) < N) ? map[rsel] : '0;
   assign ldata = (int'(lsel) < N) ? map[lsel] : '0;

   p_map_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (int'(wsel) < N)) |=> (map[$past(wsel)] == $past(wdata)));
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned PRI_N = 40,
   parameter int unsigned SEC_N = 32,
   parameter int unsigned AW    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [PRI_N-2:0] irq_pri_in,
   input  logic [SEC_N-1:0] irq_sec_in,
   output logic             cpu_irq
);
   localparam int unsigned PRI_WORDS = (PRI_N + WORD_W - 1) / WORD_W;
   localparam int unsigned EXT_W     = PRI_WORDS * WORD_W;

   generate
      if (PRI_N < 2 || PRI_N > 2 * WORD_W) begin : g_bad_pri
         $error("PRI_N must lie in 2..64");
      end
      if (SEC_N < 1 || SEC_N > WORD_W) begin : g_bad_sec
         $error("SEC_N must lie in 1..32");
      end
      if ((1 << IDX_W) <= PRI_N) begin : g_bad_idx
         $error("index field too narrow for PRI_N plus idle code");
      end
      if ((1 << AW) < A_CMAP + PRI_N) begin : g_bad_aw
         $error("AW too small for channel map");
      end
   endgenerate

   // ---------------- write decode ----------------
   logic [PRI_N-1:0] p_clr, p_set, p_dis;
   logic [SEC_N-1:0] s_clr, s_set, s_dis;

   function automatic logic hit(input logic [AW-1:0] a, input int unsigned w);
      return bus_wr && (a == AW'(w));
   endfunction

   genvar gi;
   generate
      for (gi = 0; gi < PRI_N; gi++) begin : g_pdec
         localparam int unsigned WD = gi / WORD_W;
         localparam int unsigned BT = gi % WORD_W;
         assign p_clr[gi] = hit(bus_addr, A_PCLR  + WD) && bus_wdata[BT];
         assign p_set[gi] = hit(bus_addr, A_PESET + WD) && bus_wdata[BT];
         assign p_dis[gi] = hit(bus_addr, A_PECLR + WD) && bus_wdata[BT];
      end
      for (gi = 0; gi < SEC_N; gi++) begin : g_sdec
         assign s_clr[gi] = hit(bus_addr, A_SCLR)  && bus_wdata[gi];
         assign s_set[gi] = hit(bus_addr, A_SESET) && bus_wdata[gi];
         assign s_dis[gi] = hit(bus_addr, A_SECLR) && bus_wdata[gi];
      end
   endgenerate

   // ---------------- banks ----------------
   logic [SEC_N-1:0] s_pend, s_en;
   logic [PRI_N-1:0] p_pend, p_en;
   logic             cascade;

   irqc_bank #(.N(SEC_N), .CASCADE0(1'b0)) u_sec (
      .clk(clk), .rst_n(rst_n), .raw(irq_sec_in),
      .pclr(s_clr), .eset(s_set), .eclr(s_dis),
      .pend(s_pend), .en(s_en));

   assign cascade = |(s_pend & s_en);

   irqc_bank #(.N(PRI_N), .CASCADE0(1'b1)) u_pri (
      .clk(clk), .rst_n(rst_n), .raw({irq_pri_in, cascade}),
      .pclr(p_clr), .eset(p_set), .eclr(p_dis),
      .pend(p_pend), .en(p_en));

   // ---------------- priority and remap ----------------
   logic [PRI_N-1:0] req;
   logic             found;
   idx_t             winner, mapped, map_rd, idx_out;

   assign req = p_pend & p_en;

   irqc_prio #(.N(PRI_N), .IW(IDX_W)) u_prio (
      .req(req), .found(found), .idx(winner));

   logic cm_wr;
   idx_t cm_sel;
   assign cm_sel = IDX_W'(bus_addr - AW'(A_CMAP));
   assign cm_wr  = bus_wr && (bus_addr >= AW'(A_CMAP)) &&
                   (bus_addr < AW'(A_CMAP + PRI_N));

   irqc_chanmap #(.N(PRI_N), .IW(IDX_W)) u_map (
      .clk(clk), .rst_n(rst_n),
      .wr(cm_wr), .wsel(cm_sel), .wdata(bus_wdata[IDX_W-1:0]),
      .rsel(cm_sel), .rdata(map_rd),
      .lsel(winner), .ldata(mapped));

   assign idx_out = found ? mapped : IDX_W'(PRI_N);
   assign cpu_irq = found;

   // ---------------- read mux ----------------
   logic [EXT_W-1:0] pstat_ext, pen_ext;
   assign pstat_ext = EXT_W'(p_pend);
   assign pen_ext   = EXT_W'(p_en);

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < PRI_WORDS; k++) begin
         if (bus_addr == AW'(A_PSTAT + k)) bus_rdata = pstat_ext[k*WORD_W +: WORD_W];
         if (bus_addr == AW'(A_PESET + k)) bus_rdata = pen_ext[k*WORD_W +: WORD_W];
      end
      if (bus_addr == AW'(A_INDEX)) bus_rdata = WORD_W'(idx_out);
      if (bus_addr == AW'(A_SSTAT)) bus_rdata = WORD_W'(s_pend);
      if (bus_addr == AW'(A_SESET)) bus_rdata = WORD_W'(s_en);
      if ((bus_addr >= AW'(A_CMAP)) && (bus_addr < AW'(A_CMAP + PRI_N)))
         bus_rdata = WORD_W'(map_rd);
   end

   // ---------------- assertions ----------------
   p_idle_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq |-> (idx_out == IDX_W'(PRI_N)));

   p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (req[winner] && ((req & ((PRI_N'(1) << winner) - PRI_N'(1))) == '0)));

   p_cascade_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(s_pend & s_en)) && p_en[0]) |-> (cpu_irq && (winner == '0)));

   p_irq_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> ((p_pend & p_en) != '0));
endmodule

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [38:0] irq_pri_in = '0;
   logic [31:0] irq_sec_in = '0;
   logic        cpu_irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   irq_cascade_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pri_in(irq_pri_in), .irq_sec_in(irq_sec_in), .cpu_irq(cpu_irq));

   always #5 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 10'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 10'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse_pri(input int s);
      @(negedge clk); irq_pri_in[s-1] = 1'b1;
      @(negedge clk); irq_pri_in[s-1] = 1'b0;
   endtask

   task automatic pulse_sec(input int s);
      @(negedge clk); irq_sec_in[s] = 1'b1;
      @(negedge clk); irq_sec_in[s] = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(0, v);   check("R1 primary status word0", v, 0);
      rd(1, v);   check("R1 primary status word1", v, 0);
      rd(32, v);  check("R1 secondary status", v, 0);
      rd(8, v);   check("R1 primary enables", v, 0);
      rd(16, v);  check("R1 index idle", v, 40);
      check("R1 cpu_irq low", 32'(cpu_irq), 0);
      rd(133, v); check("R1 R10 map identity ch5", v, 5);
   endtask

   task automatic t_edge;
      logic [31:0] v;
      pulse_pri(5);
      rd(0, v);  check("R2 R5 edge latched, unmasked status", v, 32'h20);
      check("R7 not enabled so no irq", 32'(cpu_irq), 0);
      rd(16, v); check("R6 disabled source not indexed", v, 40);
      @(negedge clk); irq_pri_in[5] = 1'b1;
      repeat (3) @(negedge clk);
      rd(0, v);  check("R2 held-high source latched once", v, 32'h60);
      wr(4, 32'h40);
      repeat (2) @(negedge clk);
      rd(0, v);  check("R2 high level does not relatch", v, 32'h20);
      irq_pri_in[5] = 1'b0;
   endtask

   task automatic t_enable;
      logic [31:0] v;
      wr(8, 32'h20);
      rd(8, v);  check("R4 enable readback", v, 32'h20);
      check("R7 irq with enabled pending", 32'(cpu_irq), 1);
      rd(16, v); check("R6 index source 5", v, 5);
      wr(8, 32'h0);
      rd(8, v);  check("R4 zero set bits ignored", v, 32'h20);
      wr(12, 32'h20);
      rd(8, v);  check("R4 enable cleared", v, 0);
      check("R7 irq drops when disabled", 32'(cpu_irq), 0);
      rd(0, v);  check("R5 pending kept while disabled", v, 32'h20);
   endtask

   task automatic t_prio;
      logic [31:0] v;
      pulse_pri(35);
      rd(1, v);  check("R5 word1 bit3 for source 35", v, 32'h8);
      wr(9, 32'h8);
      wr(8, 32'h20);
      rd(16, v); check("R6 lower source wins", v, 5);
      wr(4, 32'h20);
      rd(16, v); check("R3 R6 next source after clear", v, 35);
      wr(5, 32'h8);
      rd(16, v); check("R3 word5 clear, idle", v, 40);
      check("R7 irq low when all cleared", 32'(cpu_irq), 0);
   endtask

   task automatic t_race;
      logic [31:0] v;
      wr(8, 32'h20 | 32'h80);
      pulse_pri(7);
      rd(16, v); check("R6 source 7 indexed", v, 7);
      @(negedge clk);
      irq_pri_in[6] = 1'b1; bus_wr = 1'b1; bus_addr = 10'd4; bus_wdata = 32'h80;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; irq_pri_in[6] = 1'b0;
      rd(0, v);  check("R3 edge beats same-cycle clear", v, 32'h80);
      wr(4, 32'h0);
      rd(0, v);  check("R3 zero clear bits ignored", v, 32'h80);
      wr(4, 32'h80);
      rd(0, v);  check("R3 cleared", v, 0);
   endtask

   task automatic t_cascade;
      logic [31:0] v;
      pulse_sec(3);
      rd(32, v); check("R9 R2 secondary status", v, 32'h8);
      rd(0, v);  check("R8 no cascade while secondary disabled", v, 0);
      wr(36, 32'h8);
      rd(36, v); check("R9 secondary enable readback", v, 32'h8);
      rd(0, v);  check("R8 cascade shows as source 0", v, 32'h1);
      check("R8 primary bit0 disabled, no irq", 32'(cpu_irq), 0);
      wr(8, 32'h1 | 32'hA0);
      rd(16, v); check("R8 index 0 for cascade", v, 0);
      check("R8 R7 irq via cascade", 32'(cpu_irq), 1);
      wr(4, 32'h1);
      rd(16, v); check("R8 primary clear of bit0 ignored", v, 0);
      wr(34, 32'h8);
      rd(32, v); check("R9 secondary cleared", v, 0);
      rd(16, v); check("R8 cascade gone", v, 40);
      wr(38, 32'h8);
      rd(36, v); check("R9 secondary enable cleared", v, 0);
   endtask

   task automatic t_map;
      logic [31:0] v;
      wr(140, 32'd42);
      rd(140, v); check("R10 map readback", v, 42);
      wr(8, 32'h1000);
      pulse_pri(12);
      rd(16, v);  check("R10 index through map", v, 42);
      wr(4, 32'h1000);
      rd(16, v);  check("R10 idle after clear", v, 40);
      rd(167, v); check("R10 last map entry identity", v, 39);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      rd(24, v);  check("R11 hole at 0x60", v, 0);
      rd(4, v);   check("R11 clear word reads 0", v, 0);
      rd(12, v);  check("R11 enable-clear reads 0", v, 0);
      rd(168, v); check("R11 past map", v, 0);
      rd(600, v); check("R11 far address", v, 0);
   endtask

   initial begin
      #(2_000_000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_edge();
      t_enable();
      t_prio();
      t_race();
      t_cascade();
      t_map();
      t_unmapped();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule